// File: doc/BRIEF.md
# Push-button duty-cycle PWM generator

The block drives one pulse-width-modulated output from a 50 MHz clock. A frequency-select input chooses, at run time, a period of about 1 ms or about 0.1 ms. Two active-low push buttons move the duty cycle up or down in fixed 5 % steps. The step is counted once per complete press-and-release. Each button passes through a two-flop synchroniser and a counter-based debounce filter before the step logic sees it.

The duty cycle is held as a step index from 0 to 20. It converts to an 8-bit compare value equal to round(index·255/20). One output period is 255 ticks of a sawtooth counter. The output is high while the sawtooth is below the compare value. A new duty value or a new frequency takes effect only at the next period boundary, so no period is ever cut short or stretched. Reset is asynchronous and active low.

Top module: `pwm_button_dimmer`

## Requirements
- R1: While reset is asserted and right after it is released, the duty index is 0, the output is low, and the slow frequency is in use.
- R2: With the select input at 0, one output period lasts 255·DIV_SLOW clocks (196 by default, about 1 kHz). With the select input at 1, it lasts 255·DIV_FAST clocks (20 by default, about 10 kHz).
- R3: In each period the output is high for exactly D·div clocks. Here D = (index·255 + 10)/20, using integer division, and div is the active divider.
- R4: Each complete press-and-release of the up button (input driven 0, then back to 1) raises the index by exactly one. The step is applied on the debounced release. Holding the button pressed changes nothing.
- R5: Each complete press-and-release of the down button lowers the index by exactly one.
- R6: The index saturates at 0 and at 20. At 20 the output stays high for the whole period, and at 0 it stays low.
- R7: A button level is accepted only after it has been stable for DEBOUNCE_CYCLES consecutive clocks following synchronisation. Shorter pulses have no effect on the duty cycle.
- R8: A change of duty value or of frequency select is applied only at the start of the next output period. The period in progress keeps its length and its high time.
- R9: If both buttons complete their press-and-release in the same cycle, the two steps cancel and the index is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_sel | input | 1 | 0 selects the slow rate, 1 the fast rate |
| btn_up_n | input | 1 | Raw up button, low while pressed |
| btn_down_n | input | 1 | Raw down button, low while pressed |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
A wrong step index shows up one to two periods after the release that caused it. From then on, every period's high time is off by a multiple of the divider. Measuring high time over one full period therefore exposes any wrong index, mapping or saturation. An error in the tick divider or the sawtooth changes the spacing of rising edges within a single period. Filter errors in the debounce logic appear as an extra or a missing step, which the high-time measurement that follows catches.

// File: rtl/pwmbtn_pkg.sv
// Shared constants and the index-to-compare-value conversion.
// Assumes an 8-bit compare value and a sawtooth that counts 0..254.
package pwmbtn_pkg;
    localparam int DUTY_W   = 8;
    localparam int DUTY_MAX = 255;
    localparam int SAW_TOP  = 254;

    // Round index*DUTY_MAX/steps to the nearest integer.
    function automatic logic [DUTY_W-1:0] idx_to_duty(input int idx, input int steps);
        return DUTY_W'((idx * DUTY_MAX + steps / 2) / steps);
    endfunction
endpackage

// File: rtl/btn_conditioner.sv
// Conditions one raw active-low push button.
// Synchronises the button, debounces it with a stability counter, and emits
// a one-cycle click when the filtered level returns to released.
// Assumes DEBOUNCE_CYCLES >= 2.
module btn_conditioner #(
    parameter int DEBOUNCE_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic click
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);

    logic [1:0]       sync_q;
    logic             level_q;
    logic [CNT_W-1:0] cnt_q;

    // Two-flop synchroniser; the idle level is released (1).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], btn_n};
    end

    // Accept a new level after it has been stable long enough; flag releases.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b1;
            cnt_q   <= '0;
            click   <= 1'b0;
        end else begin
            click <= 1'b0;
            if (sync_q[1] == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(DEBOUNCE_CYCLES - 1)) begin
                level_q <= sync_q[1];
                cnt_q   <= '0;
                click   <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_CLICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        click |=> !click);                                               // R4
    AST_CLICK_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        click |-> level_q);                                              // R4
    AST_LEVEL_AFTER_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(cnt_q) == CNT_W'(DEBOUNCE_CYCLES - 1))); // R7
endmodule

// File: rtl/duty_stepper.sv
// Holds the duty step index, moves it one step per click with saturation,
// and converts it to the 8-bit compare value.
// Assumes inc and dec are single-cycle pulses.
module duty_stepper
    import pwmbtn_pkg::*;
#(
    parameter int STEPS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [DUTY_W-1:0] duty
);
    localparam int IDX_W = $clog2(STEPS + 1);

    logic [IDX_W-1:0] idx_q;

    // Saturating step counter; simultaneous inc and dec cancel.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (inc && !dec && idx_q != IDX_W'(STEPS)) begin
            idx_q <= idx_q + 1'b1;
        end else if (dec && !inc && idx_q != '0) begin
            idx_q <= idx_q - 1'b1;
        end
    end

    // Registered conversion of the index to the compare value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) duty <= '0;
        else        duty <= idx_to_duty(int'(idx_q), STEPS);
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(STEPS));                                         // R6
    AST_IDX_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + 1'b1)
        || (idx_q + 1'b1 == $past(idx_q)));                              // R4
    AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(idx_q));                                // R9
endmodule

// File: rtl/pwm_core.sv
// Tick divider, 255-tick sawtooth and comparator for one PWM output.
// Duty value and divider choice are latched at each period boundary.
// Assumes DIV_SLOW and DIV_FAST are both at least 1.
module pwm_core
    import pwmbtn_pkg::*;
#(
    parameter int DIV_SLOW = 196,
    parameter int DIV_FAST = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_sel,
    input  logic [DUTY_W-1:0] duty_in,
    output logic              pwm
);
    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int DIV_W   = $clog2(DIV_MAX + 1);

    logic [DIV_W-1:0]  div_act_q;
    logic [DIV_W-1:0]  tdiv_q;
    logic [DUTY_W-1:0] saw_q;
    logic [DUTY_W-1:0] duty_act_q;
    logic              tick;
    logic              period_end;

    // Tick and period-end detection.
    always_comb begin
        tick       = (tdiv_q == div_act_q - 1'b1);
        period_end = tick && (saw_q == DUTY_W'(SAW_TOP));
    end

    // Clock divider producing one tick every div_act_q clocks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tdiv_q <= '0;
        else if (tick) tdiv_q <= '0;
        else           tdiv_q <= tdiv_q + 1'b1;
    end

    // Sawtooth 0..254, plus latching of duty and divider at the boundary.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saw_q      <= '0;
            duty_act_q <= '0;
            div_act_q  <= DIV_W'(DIV_SLOW);
        end else if (period_end) begin
            saw_q      <= '0;
            duty_act_q <= duty_in;
            div_act_q  <= fast_sel ? DIV_W'(DIV_FAST) : DIV_W'(DIV_SLOW);
        end else if (tick) begin
            saw_q <= saw_q + 1'b1;
        end
    end

    // Registered comparator output.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm <= 1'b0;
        else        pwm <= (saw_q < duty_act_q);
    end

    AST_LATCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> ($stable(duty_act_q) && $stable(div_act_q)));    // R8
    AST_SAW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        saw_q <= DUTY_W'(SAW_TOP));                                      // R2
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act_q == DUTY_W'(DUTY_MAX) && $past(duty_act_q) == DUTY_W'(DUTY_MAX)) |-> pwm); // R6
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act_q == '0 && $past(duty_act_q) == '0) |-> !pwm);         // R6
endmodule

// File: rtl/pwm_button_dimmer.sv
// Top level: button conditioning, duty stepping and the PWM generator.
// Assumes freq_sel is a slow switch input; it is synchronised here.
module pwm_button_dimmer
    import pwmbtn_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 500000,
    parameter int DIV_SLOW        = 196,
    parameter int DIV_FAST        = 20,
    parameter int STEPS           = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic freq_sel,
    input  logic btn_up_n,
    input  logic btn_down_n,
    output logic pwm_out
);
    localparam int NBTN = 2;

    logic [NBTN-1:0]   raw_n;
    logic [NBTN-1:0]   clicks;
    logic [1:0]        fsel_sync_q;
    logic [DUTY_W-1:0] duty_val;

    assign raw_n = {btn_down_n, btn_up_n};

    // Two-flop synchroniser for the frequency select switch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsel_sync_q <= '0;
        else        fsel_sync_q <= {fsel_sync_q[0], freq_sel};
    end

    for (genvar g = 0; g < NBTN; g++) begin : g_btn
        btn_conditioner #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .btn_n (raw_n[g]),
            .click (clicks[g])
        );
    end

    duty_stepper #(.STEPS(STEPS)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (clicks[0]),
        .dec   (clicks[1]),
        .duty  (duty_val)
    );

    pwm_core #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_sel (fsel_sync_q[1]),
        .duty_in  (duty_val),
        .pwm      (pwm_out)
    );
endmodule

// File: tb/tb_pwm_button_dimmer.sv
module tb_pwm_button_dimmer;
    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 16;
    localparam int DIV_S      = 4;
    localparam int DIV_F      = 2;
    localparam int WATCHDOG   = 190000;
    localparam int NVEC       = 10;

    // Vector fields: [15] freq_sel, [14:10] up clicks, [9:5] down clicks, [4:0] expected index.
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0, 5'd1,  5'd0,  5'd1},
        {1'b0, 5'd3,  5'd0,  5'd4},
        {1'b1, 5'd0,  5'd1,  5'd3},
        {1'b1, 5'd10, 5'd0,  5'd13},
        {1'b0, 5'd0,  5'd5,  5'd8},
        {1'b1, 5'd12, 5'd0,  5'd20},
        {1'b1, 5'd2,  5'd0,  5'd20},
        {1'b0, 5'd0,  5'd20, 5'd0},
        {1'b0, 5'd0,  5'd1,  5'd0},
        {1'b1, 5'd7,  5'd0,  5'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic freq_sel = 1'b0;
    logic btn_up_n = 1'b1;
    logic btn_down_n = 1'b1;
    logic pwm_out;
    int   checks = 0;
    int   errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_button_dimmer #(
        .DEBOUNCE_CYCLES(DEB), .DIV_SLOW(DIV_S), .DIV_FAST(DIV_F), .STEPS(20)
    ) dut (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel),
        .btn_up_n(btn_up_n), .btn_down_n(btn_down_n), .pwm_out(pwm_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic click(input bit up, input bit dn);
        if (up) btn_up_n = 1'b0;
        if (dn) btn_down_n = 1'b0;
        step(DEB + 8);
        btn_up_n = 1'b1;
        btn_down_n = 1'b1;
        step(DEB + 8);
    endtask

    // Wait for two slow periods, then count high clocks over one full period.
    task automatic check_high(input int idx, input string req);
        int div;
        int cnt;
        step(2 * 255 * DIV_S + 20);
        div = freq_sel ? DIV_F : DIV_S;
        cnt = 0;
        repeat (255 * div) begin
            @(negedge clk);
            if (pwm_out) cnt++;
        end
        chk(req, cnt, ((idx * 255 + 10) / 20) * div);
    endtask

    task automatic wait_rise();
        logic prev;
        prev = pwm_out;
        forever begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    // Clocks from the current rising edge to the next one.
    task automatic period_len(output int n);
        logic prev;
        n = 0;
        prev = pwm_out;
        forever begin
            @(negedge clk);
            n++;
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    initial begin
        int p;
        // R1: reset state
        step(3);
        chk("R1 pwm low in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        check_high(0, "R1 index 0 after reset");

        // Vector table: R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            freq_sel = VEC[i][15];
            for (int u = 0; u < int'(VEC[i][14:10]); u++) click(1'b1, 1'b0);
            for (int d = 0; d < int'(VEC[i][9:5]); d++) click(1'b0, 1'b1);
            check_high(int'(VEC[i][4:0]), "R3/R4/R5/R6 vector");
        end

        // R7: bounces shorter than the filter are ignored
        for (int b = 0; b < 6; b++) begin
            btn_up_n = 1'b0; step(DEB / 2);
            btn_up_n = 1'b1; step(DEB / 2);
        end
        check_high(7, "R7 short pulses ignored");

        // R4: a held press does not step; the release does
        btn_up_n = 1'b0;
        check_high(7, "R4 held press no step");
        btn_up_n = 1'b1;
        step(DEB + 8);
        check_high(8, "R4 step on release");

        // R9: both buttons together cancel
        click(1'b1, 1'b1);
        check_high(8, "R9 simultaneous cancel");

        // R2: period lengths for both select values
        freq_sel = 1'b0;
        step(2 * 255 * DIV_S + 20);
        wait_rise();
        period_len(p);
        chk("R2 slow period", p, 255 * DIV_S);
        freq_sel = 1'b1;
        step(2 * 255 * DIV_S + 20);
        wait_rise();
        period_len(p);
        chk("R2 fast period", p, 255 * DIV_F);

        // R8: a select change mid-period waits for the boundary
        wait_rise();
        freq_sel = 1'b0;
        period_len(p);
        chk("R8 current period unchanged", p, 255 * DIV_F);
        period_len(p);
        chk("R8 new period applied", p, 255 * DIV_S);

        // R1: reset in mid-operation clears the output and the index
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        chk("R1 pwm low on reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        check_high(0, "R1 index cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL all: watchdog actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule